// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This block is a 16-bit up-counter that a processor reaches through a small 8-bit register window. Each count event comes either from the system clock or from the rising edges of one external input pin. A programmable prescaler divides those events by 1, 2, 4 or 8 before they reach the counter.

The external input normally passes through a two-flop synchronizer. A control bit lets the input bypass the synchronizer and drive the edge detector directly. This cuts the latency from input edge to count. The cost is that the input is sampled unsafely.

Software reads and writes the count one byte at a time. Any write to a count byte also clears the prescaler, which software cannot otherwise see. When the count wraps, the block raises a sticky interrupt flag, which software clears by writing zero to it.

Top module: `pscnt_top`

## Requirements
- R1: After a synchronous reset, every register reads 0x00 and `irq` is low.
- R2: The register at address 0 is the control register, with these fields: bit 0 is run, bit 1 selects the external input as event source, bit 2 bypasses the synchronizer, and bits 5:4 select the prescale. The other bits read 0. Address 1 is the low count byte, address 2 is the high count byte, and bit 0 of address 3 is the wrap flag.
- R3: Prescale select values 0, 1, 2 and 3 advance the counter once per 1, 2, 4 and 8 source events. The counter never moves by more than one per cycle.
- R4: When the internal source is selected, every system clock cycle in which run is 1 is one source event. Starting from a cleared prescaler, N such cycles add N >> select to the count, modulo 65536.
- R5: While run is 0, the counter and the prescaler keep their values.
- R6: A write to either count byte resets the prescaler to zero.
- R7: A write to a count byte wins over an increment in the same cycle, and the other byte keeps its value.
- R8: An increment from 0xFFFF to 0x0000 sets the wrap flag. `irq` always equals the flag.
- R9: The flag stays set until a write of 0 to bit 0 of address 3 clears it. Writing 1 has no effect. A wrap in the same cycle as a clearing write leaves the flag set.
- R10: In synchronized external mode with prescale 1, the count changes at the third rising clock edge after the input rises.
- R11: In bypass external mode with prescale 1, the count changes at the first rising clock edge after the input rises.
- R12: In either external mode, each input pulse whose high and low phases each last at least two clock cycles is counted exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| ext_in | input | 1 | External event input |
| irq | output | 1 | Wrap interrupt flag |

## Verification
The bench goes after prescaler residue. If byte writes fail to clear the prescaler, the count advances several events too early. If the mask is wrong, the ratio drifts.

It times the wrap flag edge by edge around 0xFFFF, including a clearing write in the very cycle of the wrap. A design that lets the clear win would drop the interrupt.

It measures edge-to-count latency in both external modes. A missing or extra synchronizer stage shifts the update by a cycle.

It writes a byte while counting. A design that also applied the increment, or carried into the other byte, shows an off-by-one count.

// File: rtl/pscnt_pkg.sv
package pscnt_pkg;
    parameter int CNT_W       = 16;
    parameter int BUS_W       = 8;
    parameter int PS_W        = 2;
    parameter int SYNC_STAGES = 2;
    parameter int ADDR_W      = 2;

    localparam int LANES     = CNT_W / BUS_W;
    localparam int PCNT_W    = (1 << PS_W) - 1;
    localparam int CTRL_ADDR = 0;
    localparam int LANE_BASE = 1;
    localparam int FLAG_ADDR = LANE_BASE + LANES;

    localparam int RUN_BIT = 0;
    localparam int EXT_BIT = 1;
    localparam int BYP_BIT = 2;
    localparam int PS_LSB  = 4;

    typedef struct packed {
        logic [PS_W-1:0] presc;
        logic            bypass;
        logic            ext_sel;
        logic            run;
    } ctrl_t;

    function automatic logic [PCNT_W-1:0] presc_mask(input logic [PS_W-1:0] sel);
        logic [PCNT_W-1:0] m;
        for (int b = 0; b < PCNT_W; b++) m[b] = (b < int'(sel));
        return m;
    endfunction
endpackage

// File: rtl/pscnt_tick_src.sv
module pscnt_tick_src
    import pscnt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ext_in,
    input  logic ext_sel,
    input  logic bypass,
    output logic tick
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cand;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
    end

    // Level feeding the edge detector: raw pin or last synchronizer stage.
    assign cand = bypass ? ext_in : sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= cand;
    end

    assign tick = ext_sel ? (cand & ~prev_q) : 1'b1;
endmodule

// File: rtl/pscnt_prescaler.sv
module pscnt_prescaler
    import pscnt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            tick,
    input  logic            clr,
    input  logic [PS_W-1:0] sel,
    output logic            carry
);
    logic [PCNT_W-1:0] pcnt_q;
    logic [PCNT_W-1:0] mask;
    logic              at_end;

    assign mask   = presc_mask(sel);
    assign at_end = (pcnt_q & mask) == mask;
    assign carry  = run & tick & at_end;

    always_ff @(posedge clk) begin
        if (rst || clr)       pcnt_q <= '0;
        else if (run && tick) pcnt_q <= at_end ? '0 : pcnt_q + PCNT_W'(1);
    end
endmodule

// File: rtl/pscnt_counter.sv
module pscnt_counter
    import pscnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [LANES-1:0] wr_lane,
    input  logic [BUS_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    logic [CNT_W-1:0] nxt;
    logic             any_wr;
    logic             adv;

    assign any_wr = |wr_lane;
    assign adv    = step & ~any_wr;
    assign nxt    = cnt + CNT_W'(1);
    assign wrap   = adv & (&cnt);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)             cnt[i*BUS_W +: BUS_W] <= '0;
            else if (wr_lane[i]) cnt[i*BUS_W +: BUS_W] <= wdata;
            else if (adv)        cnt[i*BUS_W +: BUS_W] <= nxt[i*BUS_W +: BUS_W];
        end
    end
endmodule

// File: rtl/pscnt_top.sv
module pscnt_top
    import pscnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              ext_in,
    output logic              irq
);
    ctrl_t            ctrl_q;
    logic             flag_q;
    logic             wr_ctrl, wr_flag;
    logic [LANES-1:0] wr_lane;
    logic             tick, carry, wrap;
    logic [CNT_W-1:0] cnt_q;
    logic             run_on;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
    assign wr_flag = bus_wr && (bus_addr == ADDR_W'(FLAG_ADDR));
    for (genvar i = 0; i < LANES; i++) begin : g_wsel
        assign wr_lane[i] = bus_wr && (bus_addr == ADDR_W'(LANE_BASE + i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.run     <= bus_wdata[RUN_BIT];
            ctrl_q.ext_sel <= bus_wdata[EXT_BIT];
            ctrl_q.bypass  <= bus_wdata[BYP_BIT];
            ctrl_q.presc   <= bus_wdata[PS_LSB +: PS_W];
        end
    end

    // Wrap has priority over a software clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)                          flag_q <= 1'b0;
        else if (wrap)                    flag_q <= 1'b1;
        else if (wr_flag && !bus_wdata[0]) flag_q <= 1'b0;
    end

    assign irq    = flag_q;
    assign run_on = ctrl_q.run;

    pscnt_tick_src u_src (
        .clk    (clk),
        .rst    (rst),
        .ext_in (ext_in),
        .ext_sel(ctrl_q.ext_sel),
        .bypass (ctrl_q.bypass),
        .tick   (tick)
    );

    pscnt_prescaler u_psc (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.run),
        .tick (tick),
        .clr  (|wr_lane),
        .sel  (ctrl_q.presc),
        .carry(carry)
    );

    pscnt_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .step   (carry),
        .wr_lane(wr_lane),
        .wdata  (bus_wdata),
        .cnt    (cnt_q),
        .wrap   (wrap)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CTRL_ADDR)) begin
            bus_rdata[RUN_BIT]           = ctrl_q.run;
            bus_rdata[EXT_BIT]           = ctrl_q.ext_sel;
            bus_rdata[BYP_BIT]           = ctrl_q.bypass;
            bus_rdata[PS_LSB +: PS_W]    = ctrl_q.presc;
        end
        if (bus_addr == ADDR_W'(FLAG_ADDR)) bus_rdata[0] = flag_q;
        for (int i = 0; i < LANES; i++) begin
            if (bus_addr == ADDR_W'(LANE_BASE + i)) bus_rdata = cnt_q[i*BUS_W +: BUS_W];
        end
    end
endmodule

// File: rtl/pscnt_checker.sv
module pscnt_checker
    import pscnt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [CNT_W-1:0]  cnt,
    input logic              run,
    input logic              irq
);
    logic wr_cnt;
    logic wr_lo;
    logic clr_flag;

    assign wr_cnt   = bus_wr && (bus_addr >= ADDR_W'(LANE_BASE)) && (bus_addr < ADDR_W'(FLAG_ADDR));
    assign wr_lo    = bus_wr && (bus_addr == ADDR_W'(LANE_BASE));
    assign clr_flag = bus_wr && (bus_addr == ADDR_W'(FLAG_ADDR)) && !bus_wdata[0];

    assert_hold_stopped_R5: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_cnt) |=> $stable(cnt));

    assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_cnt |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

    assert_write_wins_R7: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> (cnt[BUS_W-1:0] == $past(bus_wdata) &&
                   cnt[CNT_W-1:BUS_W] == $past(cnt[CNT_W-1:BUS_W])));

    assert_wrap_sets_flag_R8: assert property (@(posedge clk) disable iff (rst)
        ((cnt == '1) && !wr_cnt) ##1 (cnt == '0) |-> irq);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr_flag) |=> irq);
endmodule

bind pscnt_top pscnt_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .cnt      (cnt_q),
    .run      (run_on),
    .irq      (irq)
);

// File: tb/tb_pscnt_top.sv
module tb_pscnt_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] A_CTRL = 2'd0, A_LO = 2'd1, A_HI = 2'd2, A_FLAG = 2'd3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ext_in = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pscnt_top dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_in(ext_in), .irq(irq)
    );

    function automatic logic [7:0] mk_ctrl(bit run, bit ext, bit byp, logic [1:0] sel);
        return {2'b00, sel, 1'b0, byp, ext, run};
    endfunction

    function automatic logic [16:0] expect_cnt(logic [15:0] start, int events, int sel);
        return {1'b0, start} + 17'(events >> sel);
    endfunction

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Called at a negedge; consumes exactly one rising edge.
    task automatic wr(logic [1:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic get_cnt(output logic [15:0] c);
        logic [7:0] lo, hi;
        rd(A_LO, lo);
        rd(A_HI, hi);
        c = {hi, lo};
    endtask

    task automatic load(logic [15:0] v, logic [7:0] ctrl_stopped);
        wr(A_CTRL, ctrl_stopped);
        wr(A_LO, v[7:0]);
        wr(A_HI, v[15:8]);
        wr(A_FLAG, 8'h00);
    endtask

    // Internal source: run for k idle cycles plus the stop-write edge.
    task automatic run_internal(string req, logic [15:0] start, logic [1:0] sel, int k);
        logic [15:0] c;
        logic [16:0] e;
        load(start, mk_ctrl(0, 0, 0, sel));
        wr(A_CTRL, mk_ctrl(1, 0, 0, sel));
        repeat (k) @(negedge clk);
        wr(A_CTRL, mk_ctrl(0, 0, 0, sel));
        e = expect_cnt(start, k + 1, int'(sel));
        get_cnt(c);
        check(req, c, e[15:0]);
        check("R8 flag after run", {15'd0, irq}, {15'd0, e[16]});
    endtask

    task automatic ext_pulses(string req, bit byp, logic [15:0] start, logic [1:0] sel, int p);
        logic [15:0] c;
        logic [16:0] e;
        load(start, mk_ctrl(0, 1, byp, sel));
        wr(A_CTRL, mk_ctrl(1, 1, byp, sel));
        for (int i = 0; i < p; i++) begin
            ext_in = 1'b1;
            repeat ($urandom_range(2, 5)) @(negedge clk);
            ext_in = 1'b0;
            repeat ($urandom_range(2, 5)) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        wr(A_CTRL, mk_ctrl(0, 1, byp, sel));
        e = expect_cnt(start, p, int'(sel));
        get_cnt(c);
        check(req, c, e[15:0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] c;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check("R1 reset register", {8'd0, d}, 16'h0000);
        end
        check("R1 reset irq", {15'd0, irq}, 16'h0000);

        // R2 control map and unused bits
        wr(A_CTRL, 8'hFF);
        rd(A_CTRL, d);
        check("R2 control readback", {8'd0, d}, 16'h0037);
        wr(A_CTRL, mk_ctrl(0, 1, 0, 2'd2));
        rd(A_CTRL, d);
        check("R2 control fields", {8'd0, d}, 16'h0022);

        // R3/R4 each ratio, directed
        run_internal("R3 ratio 1", 16'h0010, 2'd0, 20);
        run_internal("R3 ratio 2", 16'h0010, 2'd1, 20);
        run_internal("R3 ratio 4", 16'h0010, 2'd2, 20);
        run_internal("R3 ratio 8", 16'h0010, 2'd3, 20);
        run_internal("R4 wrap near top", 16'hFFF8, 2'd0, 15);

        // R4 random
        for (int i = 0; i < 24; i++) begin
            logic [15:0] s;
            s = (i % 4 == 0) ? (16'hFFFF - 16'($urandom_range(0, 8))) : 16'($urandom);
            run_internal("R4 random run", s, 2'($urandom_range(0, 3)), $urandom_range(0, 60));
        end

        // R5 hold while stopped
        get_cnt(c);
        repeat (10) @(negedge clk);
        begin
            logic [15:0] c2;
            get_cnt(c2);
            check("R5 stopped hold", c2, c);
        end

        // R6 prescaler clear via high byte, then via low byte
        load(16'h0100, mk_ctrl(0, 0, 0, 2'd3));
        wr(A_CTRL, mk_ctrl(1, 0, 0, 2'd3));
        repeat (4) @(negedge clk);
        wr(A_CTRL, mk_ctrl(0, 0, 0, 2'd3));
        wr(A_HI, 8'h01);
        wr(A_CTRL, mk_ctrl(1, 0, 0, 2'd3));
        repeat (6) @(negedge clk);
        wr(A_CTRL, mk_ctrl(0, 0, 0, 2'd3));
        get_cnt(c);
        check("R6 clear on high write", c, 16'h0100);
        wr(A_CTRL, mk_ctrl(1, 0, 0, 2'd3));
        wr(A_CTRL, mk_ctrl(0, 0, 0, 2'd3));
        get_cnt(c);
        check("R6 count after 8 events", c, 16'h0101);
        wr(A_CTRL, mk_ctrl(1, 0, 0, 2'd3));
        repeat (3) @(negedge clk);
        wr(A_CTRL, mk_ctrl(0, 0, 0, 2'd3));
        wr(A_LO, 8'h01);
        wr(A_CTRL, mk_ctrl(1, 0, 0, 2'd3));
        repeat (5) @(negedge clk);
        wr(A_CTRL, mk_ctrl(0, 0, 0, 2'd3));
        get_cnt(c);
        check("R6 clear on low write", c, 16'h0101);

        // R7 write wins over increment
        load(16'h12F0, mk_ctrl(0, 0, 0, 2'd0));
        wr(A_CTRL, mk_ctrl(1, 0, 0, 2'd0));
        wr(A_LO, 8'h80);
        wr(A_CTRL, mk_ctrl(0, 0, 0, 2'd0));
        get_cnt(c);
        check("R7 write priority", c, 16'h1281);

        // R8 flag timing, R9 set-beats-clear
        load(16'hFFFE, mk_ctrl(0, 0, 0, 2'd0));
        wr(A_CTRL, mk_ctrl(1, 0, 0, 2'd0));
        @(negedge clk);
        get_cnt(c);
        check("R8 at FFFF", c, 16'hFFFF);
        check("R8 flag low before wrap", {15'd0, irq}, 16'h0000);
        wr(A_FLAG, 8'h00);
        get_cnt(c);
        check("R8 wrapped to zero", c, 16'h0000);
        check("R9 wrap beats clear", {15'd0, irq}, 16'h0001);
        wr(A_CTRL, mk_ctrl(0, 0, 0, 2'd0));
        rd(A_FLAG, d);
        check("R9 flag register", {8'd0, d}, 16'h0001);
        repeat (5) @(negedge clk);
        check("R9 sticky", {15'd0, irq}, 16'h0001);
        wr(A_FLAG, 8'h01);
        check("R9 write one ignored", {15'd0, irq}, 16'h0001);
        wr(A_FLAG, 8'h00);
        check("R9 clear", {15'd0, irq}, 16'h0000);
        wr(A_FLAG, 8'h01);
        check("R9 write one no set", {15'd0, irq}, 16'h0000);

        // R10 synchronized latency
        load(16'h0010, mk_ctrl(0, 1, 0, 2'd0));
        wr(A_CTRL, mk_ctrl(1, 1, 0, 2'd0));
        ext_in = 1'b1;
        @(negedge clk); get_cnt(c); check("R10 edge 1", c, 16'h0010);
        @(negedge clk); get_cnt(c); check("R10 edge 2", c, 16'h0010);
        @(negedge clk); get_cnt(c); check("R10 edge 3", c, 16'h0011);
        repeat (3) @(negedge clk); get_cnt(c); check("R10 counted once", c, 16'h0011);
        ext_in = 1'b0;
        repeat (4) @(negedge clk);
        wr(A_CTRL, mk_ctrl(0, 1, 0, 2'd0));

        // R11 bypass latency
        load(16'h0020, mk_ctrl(0, 1, 1, 2'd0));
        wr(A_CTRL, mk_ctrl(1, 1, 1, 2'd0));
        ext_in = 1'b1;
        @(negedge clk); get_cnt(c); check("R11 edge 1", c, 16'h0021);
        repeat (3) @(negedge clk); get_cnt(c); check("R11 counted once", c, 16'h0021);
        ext_in = 1'b0;
        repeat (4) @(negedge clk);
        wr(A_CTRL, mk_ctrl(0, 1, 1, 2'd0));

        // R12 random pulse trains in both modes
        for (int i = 0; i < 8; i++) begin
            ext_pulses("R12 pulses", i[0], 16'($urandom), 2'($urandom_range(0, 3)),
                       $urandom_range(1, 30));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule